// File: doc/BRIEF.md
# Channel Interrupt Status Aggregator

This block gathers interrupt causes from a bank of DMA channels and folds them onto a small set of level-sensitive interrupt lines. Each channel raises two kinds of event, "descriptor finished" and "error", as single-cycle pulses. Every channel keeps a private copy of its cause bits and an enable mask for each interrupt line. Software can therefore steer any channel to any line and acknowledge it there independently.

Channels come in pairs. The even member of a pair moves data toward a peripheral (transmit) and the odd member moves data from one (receive). Each line has a transmit summary word and a receive summary word, and bit n of each word stands for pair n. Each line also has a global status word for miscellaneous causes. A line is high whenever anything routed to it is pending.

A plain register port without handshake gives access to cause, mask, summary and global words. The same port reaches a pair of start/stop registers per direction, which keep a per-channel run flag that can be read back. Reads are combinational from held state. Writes take effect at the clock edge on which `reg_we` is sampled high. No part of this block streams data, so no port carries a valid/ready handshake.

Top module: `aic_irq_agg`

## Requirements
- R1: After reset every cause, mask, global and run bit reads 0, and every `irq` line is low.
- R2: A pulse on `done_pulse[c]` sets bit 0 of channel c's cause word for every line, and a pulse on `err_pulse[c]` sets bit 6. The new value can be read from the edge that samples the pulse onward.
- R3: Writing a 1 to bit 0 or bit 6 of a cause word clears that bit for that line only. Bits written as 0 are kept. All other bits read 0.
- R4: If a cause pulse arrives in the same cycle as a write that clears the same bit, the bit stays set.
- R5: Each channel has one mask word per line. Only bits 0 and 6 hold data; the other bits read 0 whatever was written.
- R6: Bit n of the transmit summary for line o is 1 when channel 2n has a cause bit that is both set and enabled in its line-o mask. Bit n of the receive summary follows channel 2n+1 by the same rule.
- R7: `irq[o]` is high exactly while line o's transmit summary, receive summary or global word is nonzero. It reflects state in the same cycle that state is readable.
- R8: Pulses on `glob_pulse` set bits of the global word of their line. A write to that word clears the bits written as 1, so writing all ones clears it. A pulse on a bit in the same cycle as its clear leaves the bit set.
- R9: Writing a mask to transmit-start sets the transmit run flag of every pair n whose mask bit n is 1, and transmit-stop clears those flags. Receive-start and receive-stop do the same for the receive flags. A read of either start address returns that direction's run flags.
- R10: The word map is as follows. Transmit-start is at 0x000, transmit-stop at 0x001, receive-start at 0x002 and receive-stop at 0x003. The transmit summary of line o is at 0x004+o, the receive summary at 0x008+o and the global word at 0x00C+o. Channel c's cause word for line o is at 0x040+8c+o, and its mask word at 0x044+8c+o. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_pulse | input | NUM_CH | Per-channel descriptor-finished pulse |
| err_pulse | input | NUM_CH | Per-channel error pulse |
| glob_pulse | input | NUM_OUT*GW | Global cause pulses, GW bits per line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | NUM_OUT | Level interrupt lines |

## Verification
Every state change lands on the single edge that samples the pulse or the write strobe. Both `reg_rdata` and `irq` are combinational from that state, so every result is due one edge after its stimulus. The bench drives stimulus on falling edges and lets one rising edge pass. It then sets the read address and samples 1 ns later, still within the low phase. The bench never samples on a rising edge, and so no check depends on the order in which processes run. The bench sweeps every channel against every line, plus all-channel patterns, global words and run flags, on an eight-channel build.

// File: rtl/aic_pkg.sv
package aic_pkg;
  // Bit positions inside cause and mask words
  localparam int DONE_BIT = 0;
  localparam int ERR_BIT  = 6;

  // Word addresses
  localparam int A_TX_GO   = 'h000;
  localparam int A_TX_HALT = 'h001;
  localparam int A_RX_GO   = 'h002;
  localparam int A_RX_HALT = 'h003;
  localparam int A_TXSUM   = 'h004;
  localparam int A_RXSUM   = 'h008;
  localparam int A_GLOB    = 'h00C;
  localparam int CH_BASE   = 'h040;
  localparam int CH_STRIDE = 8;   // four cause words, then four mask words
  localparam int MASK_OFS  = 4;
endpackage

// File: rtl/aic_chan_regs.sv
module aic_chan_regs
  import aic_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      done_p,
  input  logic                      err_p,
  input  logic                      wr_en,
  input  logic [2:0]                wr_sel,
  input  logic                      wr_done,
  input  logic                      wr_err,
  output logic [NUM_OUT-1:0][1:0]   cause_o,
  output logic [NUM_OUT-1:0][1:0]   mask_o,
  output logic [NUM_OUT-1:0]        pend_o
);
  // cause_o[o][0] = descriptor finished, cause_o[o][1] = error
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic st_wr, mk_wr;
    assign st_wr = wr_en && (wr_sel == 3'(o));
    assign mk_wr = wr_en && (wr_sel == 3'(o + MASK_OFS));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cause_o[o] <= '0;
        mask_o[o]  <= '0;
      end else begin
        // a new pulse wins over a simultaneous clear
        cause_o[o][0] <= done_p | (cause_o[o][0] & ~(st_wr & wr_done));
        cause_o[o][1] <= err_p  | (cause_o[o][1] & ~(st_wr & wr_err));
        if (mk_wr) mask_o[o] <= {wr_err, wr_done};
      end
    end

    assign pend_o[o] = |(cause_o[o] & mask_o[o]);
  end
endmodule

// File: rtl/aic_glob_status.sv
module aic_glob_status #(
  parameter int NUM_OUT = 4,
  parameter int GW      = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_OUT*GW-1:0]      set_i,
  input  logic [NUM_OUT-1:0]         wr_en,
  input  logic [GW-1:0]              wdata,
  output logic [NUM_OUT-1:0][GW-1:0] stat_o
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [GW-1:0] clr;
    assign clr = wr_en[o] ? wdata : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o[o] <= '0;
      else        stat_o[o] <= set_i[o*GW +: GW] | (stat_o[o] & ~clr);
    end
  end
endmodule

// File: rtl/aic_run_ctrl.sv
module aic_run_ctrl #(
  parameter int HALF = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_go,
  input  logic            tx_halt,
  input  logic            rx_go,
  input  logic            rx_halt,
  input  logic [HALF-1:0] wmask,
  output logic [HALF-1:0] tx_run,
  output logic [HALF-1:0] rx_run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run <= '0;
      rx_run <= '0;
    end else begin
      if (tx_go)   tx_run <= tx_run | wmask;
      if (tx_halt) tx_run <= tx_run & ~wmask;
      if (rx_go)   rx_run <= rx_run | wmask;
      if (rx_halt) rx_run <= rx_run & ~wmask;
    end
  end
endmodule

// File: rtl/aic_irq_agg.sv
module aic_irq_agg
  import aic_pkg::*;
#(
  parameter int NUM_CH  = 16,  // even, at most 64
  parameter int NUM_OUT = 4,   // at most 4
  parameter int GW      = 32,  // global word width, at most 32
  parameter int ADDR_W  = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     done_pulse,
  input  logic [NUM_CH-1:0]     err_pulse,
  input  logic [NUM_OUT*GW-1:0] glob_pulse,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic [NUM_OUT-1:0]    irq
);
  localparam int HALF  = NUM_CH / 2;
  localparam int IDX_W = ADDR_W - 3;

  // channel window decode
  logic [ADDR_W-1:0] ch_off;
  logic [IDX_W-1:0]  ch_idx;
  logic [2:0]        ch_sel;
  logic              ch_hit;

  assign ch_off = reg_addr - ADDR_W'(CH_BASE);
  assign ch_idx = ch_off[ADDR_W-1:3];
  assign ch_sel = ch_off[2:0];
  assign ch_hit = (reg_addr >= ADDR_W'(CH_BASE)) && (int'(ch_idx) < NUM_CH);

  logic [NUM_OUT-1:0][1:0] ch_cause [NUM_CH];
  logic [NUM_OUT-1:0][1:0] ch_mask  [NUM_CH];
  logic [NUM_OUT-1:0]      ch_pend  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    aic_chan_regs #(.NUM_OUT(NUM_OUT)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_p  (done_pulse[c]),
      .err_p   (err_pulse[c]),
      .wr_en   (reg_we && ch_hit && (int'(ch_idx) == c)),
      .wr_sel  (ch_sel),
      .wr_done (reg_wdata[DONE_BIT]),
      .wr_err  (reg_wdata[ERR_BIT]),
      .cause_o (ch_cause[c]),
      .mask_o  (ch_mask[c]),
      .pend_o  (ch_pend[c])
    );
  end

  // global words
  logic [NUM_OUT-1:0]         glob_wr;
  logic [NUM_OUT-1:0][GW-1:0] glob_q;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_gwr
    assign glob_wr[o] = reg_we && (reg_addr == ADDR_W'(A_GLOB + o));
  end

  aic_glob_status #(.NUM_OUT(NUM_OUT), .GW(GW)) u_glob (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (glob_pulse),
    .wr_en  (glob_wr),
    .wdata  (reg_wdata[GW-1:0]),
    .stat_o (glob_q)
  );

  // run flags
  logic [HALF-1:0] tx_run, rx_run;

  aic_run_ctrl #(.HALF(HALF)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_go   (reg_we && (reg_addr == ADDR_W'(A_TX_GO))),
    .tx_halt (reg_we && (reg_addr == ADDR_W'(A_TX_HALT))),
    .rx_go   (reg_we && (reg_addr == ADDR_W'(A_RX_GO))),
    .rx_halt (reg_we && (reg_addr == ADDR_W'(A_RX_HALT))),
    .wmask   (reg_wdata[HALF-1:0]),
    .tx_run  (tx_run),
    .rx_run  (rx_run)
  );

  // summaries: pair n -> even channel into tx, odd channel into rx
  logic [NUM_OUT-1:0][HALF-1:0] tx_sum, rx_sum;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
    for (genvar n = 0; n < HALF; n++) begin : g_pair
      assign tx_sum[o][n] = ch_pend[2*n][o];
      assign rx_sum[o][n] = ch_pend[2*n+1][o];
    end
    assign irq[o] = (|tx_sum[o]) | (|rx_sum[o]) | (|glob_q[o]);
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_TX_GO)) reg_rdata = 32'(tx_run);
    if (reg_addr == ADDR_W'(A_RX_GO)) reg_rdata = 32'(rx_run);
    for (int o = 0; o < NUM_OUT; o++) begin
      if (reg_addr == ADDR_W'(A_TXSUM + o)) reg_rdata = 32'(tx_sum[o]);
      if (reg_addr == ADDR_W'(A_RXSUM + o)) reg_rdata = 32'(rx_sum[o]);
      if (reg_addr == ADDR_W'(A_GLOB + o))  reg_rdata = 32'(glob_q[o]);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        if (ch_hit && (int'(ch_idx) == c) && (int'(ch_sel[1:0]) == o)) begin
          reg_rdata[DONE_BIT] = ch_sel[2] ? ch_mask[c][o][0] : ch_cause[c][o][0];
          reg_rdata[ERR_BIT]  = ch_sel[2] ? ch_mask[c][o][1] : ch_cause[c][o][1];
        end
      end
    end
  end
endmodule

// File: rtl/aic_irq_agg_chk.sv
module aic_irq_agg_chk
  import aic_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_OUT = 4,
  parameter int GW      = 32,
  parameter int ADDR_W  = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CH-1:0]          done_pulse,
  input logic [NUM_CH-1:0]          err_pulse,
  input logic [NUM_OUT*GW-1:0]      glob_pulse,
  input logic                       reg_we,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [31:0]                reg_wdata,
  input logic [NUM_OUT-1:0]         irq,
  input logic [NUM_OUT-1:0][1:0]    ch_cause [NUM_CH],
  input logic [NUM_OUT-1:0][GW-1:0] glob_q,
  input logic [NUM_CH/2-1:0]        tx_run,
  input logic [NUM_CH/2-1:0]        rx_run
);
  localparam int HALF = NUM_CH / 2;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
      // R2
      done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse[c] |=> ch_cause[c][o][0]);
      // R2
      err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse[c] |=> ch_cause[c][o][1]);
      // R3
      done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(CH_BASE + CH_STRIDE*c + o) &&
         reg_wdata[DONE_BIT] && !done_pulse[c]) |=> !ch_cause[c][o][0]);
      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(CH_BASE + CH_STRIDE*c + o) &&
         reg_wdata[ERR_BIT] && err_pulse[c]) |=> ch_cause[c][o][1]);
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_g
    // R8
    glob_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_GLOB + o) && (&reg_wdata[GW-1:0]) &&
       !(|glob_pulse[o*GW +: GW])) |=> (glob_q[o] == '0));
    // R7
    glob_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|glob_q[o]) |-> irq[o]);
  end

  // R9
  tx_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(A_TX_GO)) |=>
      ((tx_run & $past(reg_wdata[HALF-1:0])) == $past(reg_wdata[HALF-1:0])));
  // R9
  rx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(A_RX_HALT)) |=>
      ((rx_run & $past(reg_wdata[HALF-1:0])) == '0));
endmodule

bind aic_irq_agg aic_irq_agg_chk #(
  .NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT), .GW(GW), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_pulse (done_pulse),
  .err_pulse  (err_pulse),
  .glob_pulse (glob_pulse),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq        (irq),
  .ch_cause   (ch_cause),
  .glob_q     (glob_q),
  .tx_run     (tx_run),
  .rx_run     (rx_run)
);

// File: tb/sim_aic_irq_agg.sv
`timescale 1ns/1ps
module sim_aic_irq_agg;
  localparam int NCH = 8;
  localparam int NO  = 4;
  localparam int GWB = 8;
  localparam int AW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    done_pulse = '0;
  logic [NCH-1:0]    err_pulse  = '0;
  logic [NO*GWB-1:0] glob_pulse = '0;
  logic              reg_we = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NO-1:0]     irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  aic_irq_agg #(.NUM_CH(NCH), .NUM_OUT(NO), .GW(GWB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .glob_pulse(glob_pulse), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [AW-1:0] st_a(input int c, input int o);
    return AW'('h40 + 8*c + o);
  endfunction
  function automatic logic [AW-1:0] mk_a(input int c, input int o);
    return AW'('h44 + 8*c + o);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
    @(negedge clk);
    done_pulse = dn; err_pulse = er;
    @(negedge clk);
    done_pulse = '0; err_pulse = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(st_a(0, 0), v);     chk("R1 cause", v, 0);
    rd(mk_a(NCH-1, 3), v); chk("R1 mask", v, 0);
    rd('h00C, v);          chk("R1 glob", v, 0);
    rd('h000, v);          chk("R1 txrun", v, 0);
    rd('h002, v);          chk("R1 rxrun", v, 0);
    // R10 unmapped word
    rd('h03F, v);          chk("R10 unmapped", v, 0);

    // per channel, per line sweep
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < NO; o++) begin
        logic [31:0] exp_tx, exp_rx;
        int on;
        on = (o + 1) % NO;
        exp_tx = (c % 2 == 0) ? 32'(1) << (c / 2) : 0;
        exp_rx = (c % 2 == 1) ? 32'(1) << (c / 2) : 0;
        wr(mk_a(c, o), 32'hFFFF_FFFF);
        rd(mk_a(c, o), v); chk("R5 mask bits", v, 32'h41);
        pulse(NCH'(1) << c, '0);
        for (int o2 = 0; o2 < NO; o2++) begin
          rd(st_a(c, o2), v); chk("R2 done on all lines", v, 32'h01);
        end
        rd(AW'('h004 + o), v); chk("R6 tx sum", v, exp_tx);
        rd(AW'('h008 + o), v); chk("R6 rx sum", v, exp_rx);
        rd(AW'('h004 + on), v); chk("R6 tx sum other line", v, 0);
        chk("R7 irq one line", 32'(irq), 32'(1) << o);
        wr(st_a(c, o), 32'h40);
        rd(st_a(c, o), v); chk("R3 zero keeps", v, 32'h01);
        wr(st_a(c, o), 32'hFFFF_FFFF);
        rd(st_a(c, o), v);  chk("R3 cleared", v, 0);
        rd(st_a(c, on), v); chk("R3 other line kept", v, 32'h01);
        chk("R7 irq drops", 32'(irq), 0);
        for (int o2 = 0; o2 < NO; o2++) if (o2 != o) wr(st_a(c, o2), 32'h01);
        pulse('0, NCH'(1) << c);
        rd(st_a(c, o), v); chk("R2 err bit", v, 32'h40);
        chk("R7 irq err", 32'(irq), 32'(1) << o);
        // R4 pulse and clear in the same cycle
        @(negedge clk);
        err_pulse = NCH'(1) << c;
        reg_we = 1'b1; reg_addr = st_a(c, o); reg_wdata = 32'h41;
        @(negedge clk);
        err_pulse = '0; reg_we = 1'b0;
        rd(st_a(c, o), v); chk("R4 set wins", v, 32'h40);
        for (int o2 = 0; o2 < NO; o2++) wr(st_a(c, o2), 32'h41);
        wr(mk_a(c, o), 0);
        rd(st_a(c, o), v); chk("R3 all clear", v, 0);
        chk("R7 idle", 32'(irq), 0);
      end
    end

    // R6 all channels, line 2: even masks done only, odd masks err only
    for (int c = 0; c < NCH; c++) wr(mk_a(c, 2), (c % 2 == 0) ? 32'h01 : 32'h40);
    pulse('1, '0);
    rd('h006, v); chk("R6 tx all", v, 32'h0F);
    rd('h00A, v); chk("R6 rx masked off", v, 0);
    chk("R7 irq line2", 32'(irq), 32'h4);
    pulse('0, '1);
    rd('h00A, v); chk("R6 rx all", v, 32'h0F);
    for (int c = 0; c < NCH; c++) for (int o = 0; o < NO; o++) wr(st_a(c, o), 32'h41);
    chk("R7 irq cleared", 32'(irq), 0);

    // R8 global words
    for (int o = 0; o < NO; o++) begin
      @(negedge clk);
      glob_pulse = (NO*GWB)'(32'hA5) << (o*GWB);
      @(negedge clk);
      glob_pulse = '0;
      rd(AW'('h00C + o), v); chk("R8 glob set", v, 32'hA5);
      chk("R7 irq glob", 32'(irq), 32'(1) << o);
      wr(AW'('h00C + o), 32'h05);
      rd(AW'('h00C + o), v); chk("R8 glob partial", v, 32'hA0);
      @(negedge clk);
      glob_pulse = (NO*GWB)'(32'h03) << (o*GWB);
      reg_we = 1'b1; reg_addr = AW'('h00C + o); reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      glob_pulse = '0; reg_we = 1'b0;
      rd(AW'('h00C + o), v); chk("R8 glob set wins", v, 32'h03);
      wr(AW'('h00C + o), 32'hFFFF_FFFF);
      rd(AW'('h00C + o), v); chk("R8 glob all ones", v, 0);
      chk("R7 irq glob off", 32'(irq), 0);
    end

    // R9 run flags
    wr('h000, 32'h0A); rd('h000, v); chk("R9 tx start", v, 32'h0A);
    wr('h002, 32'h05); rd('h002, v); chk("R9 rx start", v, 32'h05);
    wr('h001, 32'h02); rd('h000, v); chk("R9 tx stop", v, 32'h08);
    rd('h002, v);      chk("R9 rx untouched", v, 32'h05);
    wr('h000, 32'hFF); rd('h000, v); chk("R9 tx width", v, 32'h0F);
    wr('h003, 32'hFF); rd('h002, v); chk("R9 rx stop all", v, 0);
    rd('h001, v);      chk("R10 stop reads zero", v, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule